// File: doc/BRIEF.md
# Serial Bus Clock Activity Watchdog

This block watches the clock line of a serial management bus and measures how long the line has stayed still. Activity is any change of level on the line. The watchdog counts ticks of a slow enable strobe that the surrounding chip supplies. If it counts a set number of ticks with no activity, it has timed out. When the watchdog is armed, a timeout resets the bus interface and switches off every powered port. Both actions are single-cycle pulses that other blocks act on.

Software turns the shutdown action on and off through a 4-bit key field. One value of the key means "off". The field holds that value after reset, so the watchdog starts disarmed. A sticky status bit records every timeout, including those that happen while the action is disarmed. Software can clear the status bit but cannot set it. Once a timeout has fired, the watchdog stays quiet until the line moves again.

Top module: `bus_wdt`

## Requirements
- R1: After reset, `if_rst_o`, `port_off_o` and `wdt_stat_o` are 0. The key field holds 4'b1011, so the shutdown action is disarmed.
- R2: `scl_i` passes through two synchronizer flops. A rising or a falling level change is detected one cycle after it reaches the second flop, and the detection restarts the tick count from zero.
- R3: A timeout fires in the cycle of the `TIMEOUT_TICKS`-th tick counted since the last restart. Its effects appear on the outputs from the next clock edge.
- R4: While armed, a timeout drives `if_rst_o` and `port_off_o` high together for exactly one cycle.
- R5: While the key field is 4'b1011, a timeout produces no pulse on `if_rst_o` or `port_off_o`, but `wdt_stat_o` still sets.
- R6: A write with `key_we_i` loads `key_wdata_i` into the key field. The value 4'b1011 disarms the shutdown action and every other value arms it. The key in effect during the cycle of the timeout decides whether the pulse occurs.
- R7: `wdt_stat_o` sets on every timeout and stays set. Only reset, or a write with `stat_we_i` and `stat_wdata_i` = 0, clears it. A write of 1 has no effect. A timeout in the same cycle as a clear leaves the bit set.
- R8: After a timeout, no further timeout occurs until at least one level change has been detected on the line.
- R9: A level change detected in the same cycle as the final tick cancels that timeout and restarts the count.
- R10: The count advances only in cycles where `tick_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line, asynchronous to clk_i |
| tick_i | input | 1 | Timebase strobe, one tick per high cycle |
| key_we_i | input | 1 | Write strobe for the key field |
| key_wdata_i | input | 4 | Key value to load |
| stat_we_i | input | 1 | Write strobe for the status bit |
| stat_wdata_i | input | 1 | Status write data; 0 clears, 1 has no effect |
| if_rst_o | output | 1 | Bus interface reset pulse |
| port_off_o | output | 1 | Latch-off pulse for all active ports |
| wdt_stat_o | output | 1 | Sticky timeout status |

## Verification
The hardest case to reach from the ports is a line change that is detected in exactly the cycle of the final tick (R9). The same applies to a status clear that lands in the cycle of a timeout (R7). Both depend on the two-cycle synchronizer latency lining up with the tick count. The stimulus sweeps the spacing between line changes, and the spacing between restart and clear, over a window around `TIMEOUT_TICKS`. This forces both coincidences. Random traffic with sparse ticks and key writes then covers the remaining interleavings.

// File: rtl/bus_wdt_pkg.sv
package bus_wdt_pkg;
  localparam int unsigned KEY_W = 4;
  localparam logic [KEY_W-1:0] WDT_OFF_KEY = 4'b1011;

  typedef struct packed {
    logic if_rst;
    logic port_off;
  } wdt_act_t;
endpackage

// File: rtl/bus_wdt_sync.sv
module bus_wdt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  output logic edge_o
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q[0] <= 1'b1;
    else         sh_q[0] <= scl_i;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q[i] <= 1'b1;
      else         sh_q[i] <= sh_q[i-1];
    end
  end

  assign edge_o = sh_q[STAGES] ^ sh_q[STAGES-1];
endmodule

// File: rtl/bus_wdt_timer.sv
module bus_wdt_timer #(
  parameter int unsigned TICKS = 2000,
  localparam int unsigned CNT_W = (TICKS > 1) ? $clog2(TICKS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             edge_i,
  output logic             fire_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             armed_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  assign fire_o = armed_q & tick_i & ~edge_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (edge_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (fire_o) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;   // hold off until the line moves again
    end else if (armed_q && tick_i) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign cnt_o   = cnt_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/bus_wdt_ctrl.sv
module bus_wdt_ctrl
  import bus_wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic             key_we_i,
  input  logic [KEY_W-1:0] key_wdata_i,
  input  logic             stat_we_i,
  input  logic             stat_wdata_i,
  output wdt_act_t         act_o,
  output logic             stat_o,
  output logic [KEY_W-1:0] key_o
);
  logic [KEY_W-1:0] key_q;
  logic             stat_q;
  wdt_act_t         act_q;
  logic             armed;

  assign armed = (key_q != WDT_OFF_KEY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) key_q <= WDT_OFF_KEY;
    else if (key_we_i) key_q <= key_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        stat_q <= 1'b0;
    else if (fire_i)                    stat_q <= 1'b1;  // set wins over clear
    else if (stat_we_i && !stat_wdata_i) stat_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else begin
      act_q.if_rst   <= fire_i & armed;
      act_q.port_off <= fire_i & armed;
    end
  end

  assign act_o  = act_q;
  assign stat_o = stat_q;
  assign key_o  = key_q;
endmodule

// File: rtl/bus_wdt.sv
module bus_wdt
  import bus_wdt_pkg::*;
#(
  parameter int unsigned TIMEOUT_TICKS = 2000,
  parameter int unsigned SYNC_STAGES   = 2,
  localparam int unsigned CNT_W = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             tick_i,
  input  logic             key_we_i,
  input  logic [KEY_W-1:0] key_wdata_i,
  input  logic             stat_we_i,
  input  logic             stat_wdata_i,
  output logic             if_rst_o,
  output logic             port_off_o,
  output logic             wdt_stat_o
);
  logic             scl_edge;
  logic             fire;
  logic [CNT_W-1:0] cnt;
  logic             armed;
  logic [KEY_W-1:0] key_q;
  wdt_act_t         act;

  bus_wdt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (scl_i),
    .edge_o (scl_edge)
  );

  bus_wdt_timer #(.TICKS(TIMEOUT_TICKS)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .edge_i  (scl_edge),
    .fire_o  (fire),
    .cnt_o   (cnt),
    .armed_o (armed)
  );

  bus_wdt_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fire_i       (fire),
    .key_we_i     (key_we_i),
    .key_wdata_i  (key_wdata_i),
    .stat_we_i    (stat_we_i),
    .stat_wdata_i (stat_wdata_i),
    .act_o        (act),
    .stat_o       (wdt_stat_o),
    .key_o        (key_q)
  );

  assign if_rst_o   = act.if_rst;
  assign port_off_o = act.port_off;
endmodule

// File: rtl/bus_wdt_chk.sv
module bus_wdt_chk #(
  parameter int unsigned CNT_W = 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             stat_we_i,
  input logic             stat_wdata_i,
  input logic             if_rst_o,
  input logic             port_off_o,
  input logic             wdt_stat_o,
  input logic             scl_edge,
  input logic             fire,
  input logic [CNT_W-1:0] cnt,
  input logic [3:0]       key_q
);
  a_r4_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    if_rst_o |=> !if_rst_o);
  a_r4_paired: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(port_off_o) |-> if_rst_o);
  a_r5_disarmed_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_q == 4'b1011) |=> !if_rst_o && !port_off_o);
  a_r7_stat_with_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    if_rst_o |-> wdt_stat_o);
  a_r7_clear_only_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wdt_stat_o) |-> $past(stat_we_i && !stat_wdata_i));
  a_r3_fire_sets_stat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> wdt_stat_o);
  a_r9_edge_no_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_edge |=> !if_rst_o);
  a_r10_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !scl_edge) |=> $stable(cnt));
endmodule

bind bus_wdt bus_wdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .stat_we_i    (stat_we_i),
  .stat_wdata_i (stat_wdata_i),
  .if_rst_o     (if_rst_o),
  .port_off_o   (port_off_o),
  .wdt_stat_o   (wdt_stat_o),
  .scl_edge     (scl_edge),
  .fire         (fire),
  .cnt          (cnt),
  .key_q        (key_q)
);

// File: tb/bus_wdt_tb.sv
module bus_wdt_tb;
  localparam int TICKS = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, tick = 1'b0, key_we = 1'b0, stat_we = 1'b0, stat_wd = 1'b0;
  logic [3:0] key_wd = 4'h0;
  logic if_rst, port_off, stat;

  int checks = 0, errors = 0, cycles = 0;
  string phase = "R1";

  always #10 clk = ~clk;

  bus_wdt #(.TIMEOUT_TICKS(TICKS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .tick_i(tick),
    .key_we_i(key_we), .key_wdata_i(key_wd), .stat_we_i(stat_we),
    .stat_wdata_i(stat_wd), .if_rst_o(if_rst), .port_off_o(port_off),
    .wdt_stat_o(stat)
  );

  // reference model built from R1..R10
  logic m_s1, m_s2, m_s3, m_arm, e_pulse, e_stat;
  int   m_cnt;
  logic [3:0] m_key;

  function automatic logic fires(logic arm, logic tk, logic ed, int c);
    return arm && tk && !ed && (c == TICKS - 1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 1; m_s2 <= 1; m_s3 <= 1; m_arm <= 1; m_cnt <= 0;
      m_key <= 4'b1011; e_pulse <= 0; e_stat <= 0;
    end else begin
      logic ed, f;
      ed = (m_s2 != m_s3);
      f  = fires(m_arm, tick, ed, m_cnt);
      m_s1 <= scl; m_s2 <= m_s1; m_s3 <= m_s2;
      if (ed) begin m_cnt <= 0; m_arm <= 1; end
      else if (f) begin m_cnt <= 0; m_arm <= 0; end
      else if (m_arm && tick) m_cnt <= m_cnt + 1;
      e_pulse <= f && (m_key != 4'b1011);
      if (f) e_stat <= 1;
      else if (stat_we && !stat_wd) e_stat <= 0;
      if (key_we) m_key <= key_wd;
    end
  end

  task automatic cmp(string nm, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %0b exp %0b at cycle %0d", phase, nm, got, exp, cycles);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cycles++;
      cmp("if_rst_o", if_rst, e_pulse);
      cmp("port_off_o", port_off, e_pulse);
      cmp("wdt_stat_o", stat, e_stat);
      key_we = 0; stat_we = 0;
    end
  endtask

  task automatic wr_key(logic [3:0] v);
    key_we = 1; key_wd = v; step(1);
  endtask

  task automatic wr_stat(logic v);
    stat_we = 1; stat_wd = v; step(1);
  endtask

  int pulses = 0;
  always @(negedge clk) if (rst_n && if_rst) pulses++;

  task automatic report;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired in phase %s", phase);
    report();
  end

  initial begin
    int seed;
    seed = $urandom(20240611);
    repeat (3) @(negedge clk);
    rst_n = 1;
    phase = "R1 reset state";
    step(3);

    // disarmed by default: status sets, no pulse
    phase = "R5 disarmed timeout";
    tick = 1; step(TICKS + 6);
    checks++;
    if (pulses != 0 || stat !== 1) begin
      errors++; $display("FAIL R5 pulses %0d stat %0b exp 0 1", pulses, stat);
    end

    phase = "R7 write one keeps status"; wr_stat(1); step(2);
    phase = "R7 write zero clears"; wr_stat(0); step(2);

    phase = "R8 no retimeout without edge"; step(3 * TICKS);
    checks++;
    if (stat !== 0) begin errors++; $display("FAIL R8 stat %0b exp 0", stat); end

    phase = "R6 arm with 1010"; wr_key(4'b1010);
    phase = "R4 armed timeout pulse";
    scl = 0; step(TICKS + 8);
    checks++;
    if (pulses != 1) begin errors++; $display("FAIL R4 pulses %0d exp 1", pulses); end
    phase = "R8 armed hold-off"; step(2 * TICKS);

    phase = "R2 both edges restart";
    for (int k = 0; k < 10; k++) begin scl = ~scl; step(TICKS - 4); end
    checks++;
    if (pulses != 1) begin errors++; $display("FAIL R2 pulses %0d exp 1", pulses); end

    phase = "R10 sparse ticks";
    tick = 0; scl = ~scl; step(3 * TICKS);
    for (int k = 0; k < 4 * TICKS; k++) begin tick = (k % 3 == 0); step(1); end

    phase = "R9 edge at final tick sweep";
    tick = 1;
    for (int off = TICKS - 3; off <= TICKS + 2; off++) begin
      scl = ~scl; step(off);
    end
    step(TICKS + 4);

    phase = "R7 clear collides with timeout";
    for (int off = TICKS - 2; off <= TICKS + 2; off++) begin
      scl = ~scl; step(off); wr_stat(0); step(TICKS);
    end

    phase = "R6 disarm with 1011 again";
    wr_key(4'b1011); scl = ~scl; step(TICKS + 6);

    phase = "R3 random traffic";
    for (int k = 0; k < 6000; k++) begin
      if ($urandom_range(0, 39) == 0) scl = ~scl;
      tick = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 99) == 0) begin
        key_we = 1;
        key_wd = $urandom_range(0, 1) ? 4'b1011 : 4'($urandom_range(0, 15));
      end
      if ($urandom_range(0, 29) == 0) begin stat_we = 1; stat_wd = 1'($urandom_range(0, 1)); end
      step(1);
    end
    report();
  end
endmodule